// File: doc/BRIEF.md
# Two-Wire Block-Access Configuration Register Slave

This block is a serial two-wire bus slave that gives a host controller access to a bank of 21 eight-bit configuration bytes. The slave samples the clock and data lines with the system clock. It resynchronises and de-glitches both lines, recognises start and stop conditions, shifts bytes in and out, and pulls the data line low for acknowledge bits and for zero data bits. The committed register contents are presented on a flat output bus for the downstream logic that consumes them.

A write uses block-write framing. After the write address, the host sends a command byte and a byte-count byte. Both are acknowledged and then discarded. Every data byte that follows lands in the next register, starting at register 0. A read returns a length byte first, then registers from 0 upward. The read length is taken from register 8. Two register pairs, 11/12 and 13/14, are updated atomically: a pair changes only when both of its bytes arrive within one transaction.

Top module: `smb_cfg_slave`

## Requirements
- R1: Address byte D2h (write) and D3h (read) are acknowledged. Any other address byte is not acknowledged, and the slave then leaves SDA released and discards all traffic until the next start condition.
- R2: In a write, the command byte and the byte-count byte are each acknowledged and have no effect on any register. Data bytes are then stored in register 0, 1, 2, … in arrival order.
- R3: Data bytes for registers 0 through 20 are acknowledged. A data byte beyond register 20 is not acknowledged and is dropped.
- R4: A write may end with a stop after any complete data byte. Registers written before the stop keep their new values, and registers after it keep their old ones.
- R5: In a read, the first byte sent is the effective read length. It is followed by register 0, 1, 2, …, each sent MSB first.
- R6: The effective read length is the value of register 8, with 00h treated as 1. Once that many registers have been sent, the slave releases SDA even if the host acknowledges, so further bytes read as FFh.
- R7: Registers 11 and 12 both change only when register 12 is written in the same transaction that wrote register 11. Otherwise both keep their previous values, and a pending register 11 byte is discarded at any start or stop.
- R8: Registers 13 and 14 follow the same all-or-nothing rule as R7.
- R9: Register 7 always reads 21h: identifier 001 in bits 7:5 and revision 00001 in bits 4:0. Writes to it are ignored. Registers 6, 19 and 20 always read 00h, and writes to them are ignored.
- R10: After reset, register 0 and registers 10 to 20 hold 00h, registers 1 to 5 hold FFh, register 8 holds 09h and register 9 holds 10h. SDA is released.
- R11: The slave only ever pulls SDA low, never drives it high, and it starts pulling SDA low only while SCL is low.
- R12: A pulse on SCL or SDA shorter than the filter length (3 system clocks) is ignored and causes neither a bit, a start nor a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_low | output | 1 | When 1 the pad pulls the data line low; when 0 it is released |
| cfg_bytes | output | 168 | Committed register contents, register i in bits 8*i+7 down to 8*i |

## Verification
The hardest states to reach are the pair-commit boundaries. A transaction must stop exactly between the two bytes of a pair. Because addressing always restarts at register 0, the bench has to stream every lower register in order to get there, and it must rewrite register 8 on the way with a value that keeps later reads sensible. The bench keeps its own model of every register. It uses write lengths of 12, 14, 15 and 22 bytes, so that each pair sees both a half write and a full write, and a whole-bank readback compares the model afterwards. Short filter glitches are injected on SDA while SCL is high, which is the point where an unfiltered line would produce a false start.

// File: rtl/smb_cfg_pkg.sv
// Shared constants, state encodings and per-register classification
// for the two-wire configuration slave.
package smb_cfg_pkg;

    localparam int          NREG    = 21;       // registers in the bank
    localparam int          IDXW    = 8;        // width of register index counters
    localparam int          CNT_IDX = 8;        // register that sets read length
    localparam int          RO_IDX  = 7;        // identifier register
    localparam int          NPAIR   = 2;        // atomic register pairs
    localparam int          PAIR_LO [NPAIR] = '{11, 13};
    localparam logic [7:0]  WR_ADDR = 8'hD2;
    localparam logic [7:0]  RD_ADDR = 8'hD3;
    localparam logic [2:0]  VENDOR  = 3'b001;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
    } eng_st_t;

    typedef enum logic [1:0] {
        PH_ADDR, PH_CMD, PH_CNT, PH_DATA
    } eng_ph_t;

    typedef enum logic [2:0] {
        K_PLAIN, K_RO, K_NULL, K_PLO, K_PHI
    } byte_kind_t;

    // Classify register i by how writes affect it.
    function automatic byte_kind_t kind_of(int i);
        byte_kind_t k;
        k = K_PLAIN;
        if (i == RO_IDX) k = K_RO;
        if (i == 6 || i == 19 || i == 20) k = K_NULL;
        for (int p = 0; p < NPAIR; p++) begin
            if (i == PAIR_LO[p])     k = K_PLO;
            if (i == PAIR_LO[p] + 1) k = K_PHI;
        end
        return k;
    endfunction

    // Pair number owning register i (0 when i belongs to no pair).
    function automatic int pair_of(int i);
        int r;
        r = 0;
        for (int p = 0; p < NPAIR; p++)
            if (i == PAIR_LO[p] || i == PAIR_LO[p] + 1) r = p;
        return r;
    endfunction

    // Reset value of storage register i.
    function automatic logic [7:0] def_byte(int i);
        logic [7:0] v;
        v = 8'h00;
        if (i >= 1 && i <= 5) v = 8'hFF;
        if (i == CNT_IDX)     v = 8'h09;
        if (i == 9)           v = 8'h10;
        return v;
    endfunction

endpackage

// File: rtl/smb_line_filter.sv
// Resynchronises one bus line into the clk domain and removes pulses
// shorter than FILT_LEN clocks. Assumes the line idles high.
module smb_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   out_q;

    // Metastability chain toward the filter.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    // Flip the output only after FILT_LEN consecutive differing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b1;
            run_q <= '0;
        end else if (sync_q[SYNC_STAGES-1] == out_q) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_LEN - 1)) begin
            out_q <= ~out_q;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign line_o = out_q;

    // A filtered edge needs FILT_LEN stable samples behind it.
    assert_filter_settled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q != $past(out_q)) |-> (sync_q[SYNC_STAGES-1] == out_q || FILT_LEN == 1 || $past(run_q) != '0));

endmodule

// File: rtl/smb_bus_engine.sv
// Bus protocol engine: start/stop detection, bit shifting, acknowledge
// and read-data drive. Assumes filtered, clk-synchronous SCL/SDA and
// a host that never stretches or arbitrates.
module smb_bus_engine
    import smb_cfg_pkg::*;
#(
    parameter int NR = NREG,
    parameter int IW = IDXW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_f,
    input  logic          sda_f,
    input  logic [7:0]    rd_data,
    input  logic [8:0]    rd_len,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic [IW-1:0] rd_idx,
    output logic          txn_edge
);
    eng_st_t       st_q;
    eng_ph_t       ph_q;
    logic [3:0]    bit_q;
    logic [7:0]    sh_q;
    logic          rd_mode_q;
    logic          mack_q;
    logic [IW-1:0] idx_q;
    logic          oe_q;
    logic          scl_q, sda_q;

    logic scl_rise, scl_fall, start_c, stop_c, byte_done;

    // Previous filtered line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign start_c   = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_c    = scl_f & scl_q & ~sda_q & sda_f;
    assign byte_done = (st_q == ST_RX) && scl_fall && (bit_q == 4'd8);

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            ph_q      <= PH_ADDR;
            bit_q     <= '0;
            sh_q      <= '0;
            rd_mode_q <= 1'b0;
            mack_q    <= 1'b0;
            idx_q     <= '0;
            oe_q      <= 1'b0;
        end else if (start_c) begin
            st_q  <= ST_RX;
            ph_q  <= PH_ADDR;
            bit_q <= '0;
            oe_q  <= 1'b0;
        end else if (stop_c) begin
            st_q <= ST_IDLE;
            oe_q <= 1'b0;
        end else begin
            case (st_q)
                ST_RX: begin
                    if (scl_rise && bit_q < 4'd8) begin
                        sh_q  <= {sh_q[6:0], sda_f};
                        bit_q <= bit_q + 1'b1;
                    end else if (byte_done) begin
                        case (ph_q)
                            PH_ADDR: begin
                                if (sh_q == WR_ADDR || sh_q == RD_ADDR) begin
                                    rd_mode_q <= (sh_q == RD_ADDR);
                                    oe_q      <= 1'b1;
                                    st_q      <= ST_RX_ACK;
                                end else begin
                                    st_q <= ST_IDLE;
                                end
                            end
                            PH_DATA: begin
                                if (idx_q < IW'(NR)) begin
                                    oe_q <= 1'b1;
                                    st_q <= ST_RX_ACK;
                                end else begin
                                    st_q <= ST_IDLE;
                                end
                            end
                            default: begin
                                oe_q <= 1'b1;
                                st_q <= ST_RX_ACK;
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        bit_q <= '0;
                        if (ph_q == PH_ADDR && rd_mode_q) begin
                            st_q  <= ST_TX;
                            ph_q  <= PH_CNT;
                            idx_q <= '0;
                            sh_q  <= rd_len[7:0];
                            oe_q  <= ~rd_len[7];
                        end else begin
                            oe_q <= 1'b0;
                            st_q <= ST_RX;
                            case (ph_q)
                                PH_ADDR: ph_q <= PH_CMD;
                                PH_CMD:  ph_q <= PH_CNT;
                                PH_CNT: begin
                                    ph_q  <= PH_DATA;
                                    idx_q <= '0;
                                end
                                default: idx_q <= idx_q + 1'b1;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise && bit_q < 4'd8) begin
                        bit_q <= bit_q + 1'b1;
                    end else if (scl_fall) begin
                        if (bit_q == 4'd8) begin
                            oe_q <= 1'b0;
                            st_q <= ST_TX_ACK;
                            if (ph_q == PH_DATA) idx_q <= idx_q + 1'b1;
                        end else begin
                            sh_q <= {sh_q[6:0], 1'b0};
                            oe_q <= ~sh_q[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_f;
                    end else if (scl_fall) begin
                        if (mack_q && (ph_q == PH_CNT || {1'b0, idx_q} < rd_len)) begin
                            st_q  <= ST_TX;
                            ph_q  <= PH_DATA;
                            bit_q <= '0;
                            sh_q  <= rd_data;
                            oe_q  <= ~rd_data[7];
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                default: oe_q <= 1'b0;
            endcase
        end
    end

    assign sda_oe   = oe_q;
    assign wr_en    = byte_done && (ph_q == PH_DATA) && (idx_q < IW'(NR)) && !start_c && !stop_c;
    assign wr_idx   = idx_q;
    assign wr_data  = sh_q;
    assign rd_idx   = idx_q;
    assign txn_edge = start_c | stop_c;

    // The slave begins pulling SDA only while SCL is low.
    assert_oe_rise_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> !scl_f);

    // An idle slave keeps SDA released.
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !$past(start_c)) |-> !oe_q);

    // A foreign address is never acknowledged.
    assert_nack_foreign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && ph_q == PH_ADDR && sh_q != WR_ADDR && sh_q != RD_ADDR && !start_c && !stop_c)
        |=> !oe_q);

    // No register write past the end of the bank.
    assert_wr_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IW'(NR)));

endmodule

// File: rtl/smb_reg_bank.sv
// Register file: plain, read-only, write-ignored and atomically paired
// bytes. Assumes the engine supplies at most one write per clock and
// pulses txn_edge on every start and stop condition.
module smb_reg_bank
    import smb_cfg_pkg::*;
#(
    parameter int         NR  = NREG,
    parameter int         IW  = IDXW,
    parameter logic [4:0] REV = 5'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic          txn_edge,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic [8:0]    rd_len,
    output logic [NR*8-1:0] cfg_flat
);
    logic [7:0] view  [NR];
    logic [7:0] stage [NPAIR];
    logic       pend  [NPAIR];
    logic       commit[NPAIR];

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam int LO = PAIR_LO[p];

        // Hold the low byte of a pair until its partner arrives.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[p]  <= 1'b0;
                stage[p] <= '0;
            end else if (txn_edge) begin
                pend[p] <= 1'b0;
            end else if (wr_en && wr_idx == IW'(LO)) begin
                stage[p] <= wr_data;
                pend[p]  <= 1'b1;
            end else if (wr_en && wr_idx == IW'(LO + 1)) begin
                pend[p] <= 1'b0;
            end
        end

        assign commit[p] = wr_en && (wr_idx == IW'(LO + 1)) && pend[p];
    end

    for (genvar i = 0; i < NR; i++) begin : g_byte
        localparam byte_kind_t K = kind_of(i);
        localparam int         P = pair_of(i);

        if (K == K_RO) begin : g_ro
            assign view[i] = {VENDOR, REV};
        end else if (K == K_NULL) begin : g_null
            assign view[i] = 8'h00;
        end else if (K == K_PLO) begin : g_plo
            logic [7:0] q;
            // Low pair byte loads from staging on commit.
            always_ff @(posedge clk) begin
                if (!rst_n)         q <= def_byte(i);
                else if (commit[P]) q <= stage[P];
            end
            assign view[i] = q;
        end else if (K == K_PHI) begin : g_phi
            logic [7:0] q;
            // High pair byte loads from the bus on commit.
            always_ff @(posedge clk) begin
                if (!rst_n)         q <= def_byte(i);
                else if (commit[P]) q <= wr_data;
            end
            assign view[i] = q;
        end else begin : g_plain
            logic [7:0] q;
            // Plain byte loads directly from the bus.
            always_ff @(posedge clk) begin
                if (!rst_n)                             q <= def_byte(i);
                else if (wr_en && wr_idx == IW'(i))     q <= wr_data;
            end
            assign view[i] = q;
        end

        assign cfg_flat[8*i +: 8] = view[i];
    end

    // Read mux; indices past the bank read as zero.
    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < NR; k++)
            if (rd_idx == IW'(k)) rd_data = view[k];
    end

    assign rd_len = (view[CNT_IDX] == 8'h00) ? 9'd1 : {1'b0, view[CNT_IDX]};

    // Pair bytes move only on a commit.
    assert_pair0_atomic_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (view[PAIR_LO[0]] != $past(view[PAIR_LO[0]])) |-> $past(commit[0]));
    assert_pair1_atomic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (view[PAIR_LO[1]+1] != $past(view[PAIR_LO[1]+1])) |-> $past(commit[1]));

endmodule

// File: rtl/smb_cfg_slave.sv
// Top level: two line filters, the protocol engine and the register
// bank. Assumes clk is at least 20x the bus bit rate and SDA is
// open-drain at the pad (sda_pull_low enables the low driver).
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int         NR          = NREG,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3,
    parameter logic [4:0] REV         = 5'h01
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_pull_low,
    output logic [NR*8-1:0] cfg_bytes
);
    localparam int IW = IDXW;

    logic [1:0]    raw, filt;
    logic          wr_en, txn_edge;
    logic [IW-1:0] wr_idx, rd_idx;
    logic [7:0]    wr_data, rd_data;
    logic [8:0]    rd_len;

    assign raw = {sda_i, scl_i};

    for (genvar l = 0; l < 2; l++) begin : g_line
        smb_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw[l]),
            .line_o (filt[l])
        );
    end

    smb_bus_engine #(.NR(NR), .IW(IW)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (filt[0]),
        .sda_f    (filt[1]),
        .rd_data  (rd_data),
        .rd_len   (rd_len),
        .sda_oe   (sda_pull_low),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .txn_edge (txn_edge)
    );

    smb_reg_bank #(.NR(NR), .IW(IW), .REV(REV)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .txn_edge (txn_edge),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .rd_len   (rd_len),
        .cfg_flat (cfg_bytes)
    );

endmodule

// File: tb/smb_cfg_slave_bench.sv
// Directed bench: bit-banged host, one task per scenario, register model.
module smb_cfg_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;      // clocks per quarter bit
    localparam int NR         = 21;
    localparam int WD_CYCLES  = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NR*8-1:0] cfg;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int oe_bad = 0;
    logic oe_d = 1'b0;
    bit glitch = 1'b0;

    logic [7:0] expv [NR];
    logic [7:0] wbuf [32];
    logic [7:0] rbuf [32];
    bit         dack [32];
    bit         ack_a, ack_c, ack_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_cfg_slave u_smb_cfg_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_pull_low (sda_oe),
        .cfg_bytes    (cfg)
    );

    // R11 monitor: pull-down must start only while SCL is low.
    always @(negedge clk) begin
        if (rst_n && sda_oe && !oe_d && scl_m) oe_bad++;
        oe_d <= sda_oe;
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic waitq(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b1; waitq(Q);
    endtask

    task automatic put_bit(bit b);
        sda_m = b; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        if (glitch && b) begin
            sda_m = 1'b0; waitq(1);
            sda_m = 1'b1;
        end
        waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        b = sda_line; waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic send_byte(logic [7:0] v, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        ack = !a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit do_ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!do_ack);
    endtask

    // Block write of n data bytes taken from wbuf.
    task automatic do_write(int n);
        bus_start();
        send_byte(8'hD2, ack_a);
        send_byte(8'hA5, ack_c);
        send_byte(8'(n), ack_n);
        for (int i = 0; i < n; i++) send_byte(wbuf[i], dack[i]);
        bus_stop();
    endtask

    // Read: rbuf[0] is the length byte, then n data bytes; last acked if ack_last.
    task automatic do_read(int n, bit ack_last);
        bus_start();
        send_byte(8'hD3, ack_a);
        recv_byte(rbuf[0], 1'b1);
        for (int i = 1; i <= n; i++) recv_byte(rbuf[i], (i < n) || ack_last);
        bus_stop();
    endtask

    function automatic logic [7:0] cfg_at(int i);
        return cfg[8*i +: 8];
    endfunction

    // Model update: store wbuf[0..n-1] following the write rules.
    task automatic model_write(int n);
        logic [7:0] hold [2];
        for (int i = 0; i < n && i < NR; i++) begin
            if (i == 6 || i == 7 || i == 19 || i == 20) continue;
            if (i == 11 || i == 13) continue;
            if (i == 12 || i == 14) begin
                expv[i-1] = wbuf[i-1];
                expv[i]   = wbuf[i];
                continue;
            end
            expv[i] = wbuf[i];
        end
        hold[0] = 8'h00; hold[1] = hold[0];
    endtask

    task automatic cmp_all(string req);
        for (int i = 0; i < NR; i++)
            chk(req, $sformatf("cfg byte %0d", i), cfg_at(i), expv[i]);
    endtask

    task automatic t_reset();
        chk("R10", "sda released after reset", sda_oe, 0);
        cmp_all("R10");
        chk("R9", "id register", cfg_at(7), 8'h21);
    endtask

    task automatic t_default_read();
        do_read(9, 1'b0);
        chk("R1", "read address ack", ack_a, 1);
        chk("R5", "length byte first", rbuf[0], 9);
        for (int i = 0; i < 9; i++)
            chk("R5", $sformatf("read byte %0d", i), rbuf[i+1], expv[i]);
    endtask

    task automatic t_bad_addr();
        bit a;
        bus_start();
        send_byte(8'hA4, a);
        chk("R1", "foreign address not acked", a, 0);
        send_byte(8'hD2, a);
        chk("R1", "ignored until next start", a, 0);
        send_byte(8'h5A, a);
        bus_stop();
        chk("R1", "register 0 untouched", cfg_at(0), expv[0]);
    endtask

    task automatic t_short_write();
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write(3);
        chk("R1", "write address ack", ack_a, 1);
        chk("R2", "command byte ack", ack_c, 1);
        chk("R2", "count byte ack", ack_n, 1);
        chk("R3", "data ack", dack[2], 1);
        model_write(3);
        cmp_all("R4");
    endtask

    task automatic fill(int n, logic [7:0] base);
        for (int i = 0; i < n; i++) wbuf[i] = base + 8'(i);
    endtask

    task automatic t_pair_half();
        fill(12, 8'h40);
        wbuf[6] = 8'h77; wbuf[7] = 8'h00; wbuf[8] = 8'h0C; wbuf[11] = 8'h5A;
        do_write(12);
        model_write(11);
        chk("R7", "lone low byte not committed", cfg_at(11), 8'h00);
        chk("R9", "ignored byte 6", cfg_at(6), 8'h00);
        chk("R9", "read-only byte 7", cfg_at(7), 8'h21);
        do_read(12, 1'b0);
        chk("R6", "length from register 8", rbuf[0], 12);
        chk("R7", "readback byte 11", rbuf[12], 8'h00);
        cmp_all("R2");
    endtask

    task automatic t_pair_full();
        wbuf[8] = 8'h0F;
        wbuf[11] = 8'hA1; wbuf[12] = 8'hB2; wbuf[13] = 8'hC3; wbuf[14] = 8'hD4;
        do_write(15);
        model_write(15);
        chk("R7", "pair 11 committed", cfg_at(11), 8'hA1);
        chk("R7", "pair 12 committed", cfg_at(12), 8'hB2);
        chk("R8", "pair 13 committed", cfg_at(13), 8'hC3);
        chk("R8", "pair 14 committed", cfg_at(14), 8'hD4);
    endtask

    task automatic t_pair2_half();
        wbuf[11] = 8'h12; wbuf[12] = 8'h34; wbuf[13] = 8'hEE;
        do_write(14);
        model_write(13);
        chk("R8", "lone byte 13 dropped", cfg_at(13), 8'hC3);
        chk("R8", "byte 14 kept", cfg_at(14), 8'hD4);
        chk("R7", "pair 11 new", cfg_at(11), 8'h12);
        cmp_all("R8");
    endtask

    task automatic t_overrun();
        fill(22, 8'h80);
        wbuf[8] = 8'h15;
        do_write(22);
        chk("R3", "byte 20 acked", dack[20], 1);
        chk("R3", "byte 21 not acked", dack[21], 0);
        model_write(22);
        chk("R9", "byte 19 ignored", cfg_at(19), 8'h00);
        do_read(21, 1'b0);
        chk("R6", "full length", rbuf[0], 21);
        for (int i = 0; i < NR; i++)
            chk("R5", $sformatf("full readback %0d", i), rbuf[i+1], expv[i]);
    endtask

    task automatic t_glitch();
        bus_start();
        send_byte(8'hD2, ack_a);
        send_byte(8'h00, ack_c);
        send_byte(8'h01, ack_n);
        glitch = 1'b1;
        send_byte(8'hB7, dack[0]);
        glitch = 1'b0;
        bus_stop();
        expv[0] = 8'hB7;
        chk("R12", "glitched byte acked", dack[0], 1);
        chk("R12", "glitched byte stored", cfg_at(0), 8'hB7);
        chk("R12", "byte 1 untouched", cfg_at(1), expv[1]);
    endtask

    task automatic t_len_zero();
        for (int i = 0; i < 9; i++) wbuf[i] = expv[i];
        wbuf[8] = 8'h00;
        do_write(9);
        model_write(9);
        do_read(2, 1'b1);
        chk("R6", "zero count reads as one", rbuf[0], 1);
        chk("R6", "single byte", rbuf[1], expv[0]);
        chk("R6", "released after length", rbuf[2], 8'hFF);
    endtask

    task automatic t_len_three();
        for (int i = 0; i < 9; i++) wbuf[i] = expv[i];
        wbuf[8] = 8'h03;
        do_write(9);
        model_write(9);
        do_read(4, 1'b1);
        chk("R6", "length three", rbuf[0], 3);
        chk("R5", "third byte", rbuf[3], expv[2]);
        chk("R6", "fourth byte released", rbuf[4], 8'hFF);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin : wd
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL all watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < NR; i++) begin
            expv[i] = 8'h00;
            if (i >= 1 && i <= 5) expv[i] = 8'hFF;
        end
        expv[7] = 8'h21; expv[8] = 8'h09; expv[9] = 8'h10;
        waitq(5);
        rst_n = 1'b1;
        waitq(5);
        t_reset();
        t_default_read();
        t_bad_addr();
        t_short_write();
        t_pair_half();
        t_pair_full();
        t_pair2_half();
        t_overrun();
        t_glitch();
        t_len_zero();
        t_len_three();
        chk("R11", "pull-down starts with SCL high", oe_bad, 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule